// File: doc/BRIEF.md
# Tiled/Linear Image Blit Converter

The block copies a rectangular image from a source buffer to a destination buffer in one byte-wide memory. During the copy it changes the pixel format and moves between a linear layout (plain raster order) and a tiled layout (8x8 tiles in Morton order, stacked into 8-row bands). It can also shrink the image by averaging neighbouring source pixels and can mirror it top to bottom.

A transfer starts with a one-cycle `start_i` pulse, which captures all configuration inputs. The engine walks the output pixels in raster order. For each pixel it computes a source and a destination byte offset. It then reads one, two or four source pixels one byte at a time, decodes and averages them, and writes the encoded result one byte at a time. An invalid configuration is refused with an `err_o` pulse and touches no memory. A completed transfer ends with a `done_o` pulse.

Top module: `blit_xfer`

## Requirements
- R1: Format codes and pixel sizes are 0 = RGBA8 (4 bytes), 1 = RGB8 (3 bytes), 2 = RGB565, 3 = RGB5A1 and 4 = RGBA4 (2 bytes each). Pixels are stored little-endian. The RGBA8 word is R[31:24] G[23:16] B[15:8] A[7:0]. The RGB8 word is R[23:16] G[15:8] B[7:0]. RGB565 is R[15:11] G[10:5] B[4:0]. RGB5A1 is R[15:11] G[10:6] B[5:1] A[0]. RGBA4 is R[15:12] G[11:8] B[7:4] A[3:0].
- R2: Decoding widens each channel to 8 bits by repeating its bits from the top. A format without alpha decodes as alpha 255. Encoding keeps the top bits of each channel. The 1-bit alpha is 1 when the 8-bit alpha is 128 or more. Unused high bits of an encoded RGB8 word are written as zero.
- R3: `lin_in_i` and `keep_layout_i` select the layouts. With (1,0) the source is linear and the destination tiled. With (1,1) both are linear. With (0,0) the source is tiled and the destination linear. With (0,1) both are tiled.
- R4: A linear pixel sits at (y*w + x)*bpp. A tiled pixel sits at ((y & ~7)*w + (x & ~7)*8 + m)*bpp, where m interleaves the low three bits of x and y with x0 as the least significant bit. The source uses w = input width. The destination uses w = the output width used for the walk.
- R5: Scale mode 0 is none, 1 is horizontal and 2 is both axes. In each scaled axis the walk extent is the configured output extent shifted right by one, and the source coordinate is the output coordinate shifted left by one. An extent that shifts to zero gives a `done_o` pulse with no memory access.
- R6: Mode 1 averages the addressed source pixel and the next pixel in memory. Mode 2 averages four consecutive source pixels. The channel sum is divided by 2 or 4 with truncation.
- R7: With `flip_i` set, output row y is written to row (walk height - 1 - y). The source row is still derived from the unflipped y.
- R8: A start is refused when the scale mode is 3, when scaling is requested with linear input, when any configured width or height is zero, or when either format code is above 4. A refusal pulses `err_o` in the cycle after the start edge, leaves `busy_o` low and writes no memory.
- R9: An accepted start raises `busy_o` in the next cycle. After the last output byte is written, `busy_o` falls and `done_o` pulses for exactly one cycle.
- R10: The memory port moves one byte per access. Read data is taken in the cycle after `mem_rd_o`. A read and a write never happen in the same cycle, and there is no access while idle.
- R11: `start_i` and configuration changes while busy have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the configuration |
| src_base_i | input | AW | Source buffer byte address |
| dst_base_i | input | AW | Destination buffer byte address |
| in_w_i | input | CW | Source width in pixels |
| in_h_i | input | CW | Source height in pixels |
| out_w_i | input | CW | Configured output width |
| out_h_i | input | CW | Configured output height |
| in_fmt_i | input | 3 | Source format code |
| out_fmt_i | input | 3 | Destination format code |
| lin_in_i | input | 1 | Source is linear |
| keep_layout_i | input | 1 | Keep the layout rather than swap it |
| flip_i | input | 1 | Vertical mirror |
| scale_i | input | 2 | Downscale mode |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle refusal pulse |
| mem_addr_o | output | AW | Memory byte address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the strobe |

## Verification
Three results are due at fixed times. `busy_o` and `err_o` reflect a start in the cycle right after the start edge, so the bench samples them at the next falling edge. `done_o` appears in the cycle after the edge that commits the final destination byte, so destination memory is compared with the arithmetic model only once `done_o` is seen. The bench samples again one falling edge later to confirm that the pulse has ended and `busy_o` is low. For a refused start, it waits several cycles and then confirms that the destination window still holds its fill pattern.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_ACC, S_WR} xfer_st_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [7:0] a;
  } rgba_t;

  function automatic logic [2:0] px_bytes(logic [2:0] fmt);
    case (fmt)
      3'd0:    return 3'd4;
      3'd1:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic rgba_t px_decode(logic [2:0] fmt, logic [31:0] raw);
    rgba_t p;
    case (fmt)
      3'd0: p = raw;
      3'd1: p = {raw[23:0], 8'hff};
      3'd2: p = {raw[15:11], raw[15:13], raw[10:5], raw[10:9], raw[4:0], raw[4:2], 8'hff};
      3'd3: p = {raw[15:11], raw[15:13], raw[10:6], raw[10:8], raw[5:1], raw[5:3], {8{raw[0]}}};
      default: p = {raw[15:12], raw[15:12], raw[11:8], raw[11:8],
                    raw[7:4], raw[7:4], raw[3:0], raw[3:0]};
    endcase
    return p;
  endfunction

  function automatic logic [31:0] px_encode(logic [2:0] fmt, rgba_t p);
    case (fmt)
      3'd0: return p;
      3'd1: return {8'h00, p.r, p.g, p.b};
      3'd2: return {16'h0, p.r[7:3], p.g[7:2], p.b[7:3]};
      3'd3: return {16'h0, p.r[7:3], p.g[7:3], p.b[7:3], p.a[7]};
      default: return {16'h0, p.r[7:4], p.g[7:4], p.b[7:4], p.a[7:4]};
    endcase
  endfunction

endpackage

// File: rtl/blit_offset.sv
module blit_offset #(
  parameter int CW  = 8,
  parameter int OFW = 2*CW+3
) (
  input  logic [CW-1:0]  x_i,
  input  logic [CW-1:0]  y_i,
  input  logic [CW-1:0]  w_i,
  input  logic           tiled_i,
  input  logic [2:0]     bpp_i,
  output logic [OFW-1:0] off_o
);
  localparam int IW = 2*CW;

  logic [IW-1:0] row_px, idx;
  logic [5:0]    morton;

  assign morton = {y_i[2], x_i[2], y_i[1], x_i[1], y_i[0], x_i[0]};

  always_comb begin
    if (tiled_i) begin
      row_px = IW'({y_i[CW-1:3], 3'b000}) * IW'(w_i);
      idx    = row_px + IW'({x_i[CW-1:3], 6'b0}) + IW'(morton);
    end else begin
      row_px = IW'(y_i) * IW'(w_i);
      idx    = row_px + IW'(x_i);
    end
    off_o = OFW'(idx) * OFW'(bpp_i);
  end
endmodule

// File: rtl/blit_accum.sv
module blit_accum
  import blit_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       add_i,
  input  rgba_t      px_i,
  input  logic [1:0] sh_i,
  output rgba_t      avg_o
);
  logic [3:0][7:0] px_ch, avg_ch;

  assign px_ch = px_i;
  assign avg_o = rgba_t'(avg_ch);

  for (genvar c = 0; c < 4; c++) begin : g_ch
    logic [9:0] acc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (add_i) acc_q <= acc_q + 10'(px_ch[c]);
    end
    assign avg_ch[c] = 8'(acc_q >> sh_i);
  end
endmodule

// File: rtl/blit_xfer.sv
module blit_xfer
  import blit_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [CW-1:0] in_w_i,
  input  logic [CW-1:0] in_h_i,
  input  logic [CW-1:0] out_w_i,
  input  logic [CW-1:0] out_h_i,
  input  logic [2:0]    in_fmt_i,
  input  logic [2:0]    out_fmt_i,
  input  logic          lin_in_i,
  input  logic          keep_layout_i,
  input  logic          flip_i,
  input  logic [1:0]    scale_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);
  localparam int OFW = 2*CW+3;

  xfer_st_e        st_q;
  logic [AW-1:0]   src_base_q, dst_base_q;
  logic [CW-1:0]   in_w_q, ow_q, oh_q, x_q, y_q;
  logic [2:0]      in_fmt_q, out_fmt_q;
  logic            src_tiled_q, dst_tiled_q, flip_q, hs_q, vs_q;
  logic [1:0]      k_q, b_q;
  logic [3:0][7:0] buf_q;

  logic            reject, hs_n, vs_n;
  logic [CW-1:0]   ow_n, oh_n, ix, iy, oy;
  logic [2:0]      sbpp, dbpp;
  logic [OFW-1:0]  src_off, dst_off;
  logic [4:0]      k_ofs;
  logic [AW-1:0]   src_addr, dst_addr;
  logic [1:0]      last_k, acc_sh;
  logic            rd_last, wr_last, acc_clr;
  rgba_t           px_in, px_avg;
  logic [31:0]     enc;

  assign reject = (scale_i == 2'd3) | (lin_in_i & (scale_i != 2'd0)) |
                  (in_w_i == '0) | (in_h_i == '0) | (out_w_i == '0) | (out_h_i == '0) |
                  (in_fmt_i > 3'd4) | (out_fmt_i > 3'd4);
  assign hs_n = scale_i != 2'd0;
  assign vs_n = scale_i == 2'd2;
  assign ow_n = out_w_i >> hs_n;
  assign oh_n = out_h_i >> vs_n;

  assign sbpp = px_bytes(in_fmt_q);
  assign dbpp = px_bytes(out_fmt_q);
  assign ix   = x_q << hs_q;
  assign iy   = y_q << vs_q;
  // mirror after the source row has been derived
  assign oy   = flip_q ? (oh_q - CW'(1) - y_q) : y_q;

  blit_offset #(.CW(CW), .OFW(OFW)) u_src_off (
    .x_i(ix), .y_i(iy), .w_i(in_w_q), .tiled_i(src_tiled_q), .bpp_i(sbpp), .off_o(src_off)
  );
  blit_offset #(.CW(CW), .OFW(OFW)) u_dst_off (
    .x_i(x_q), .y_i(oy), .w_i(ow_q), .tiled_i(dst_tiled_q), .bpp_i(dbpp), .off_o(dst_off)
  );

  assign k_ofs    = 5'(k_q) * 5'(sbpp);
  assign src_addr = src_base_q + AW'(src_off) + AW'(k_ofs) + AW'(b_q);
  assign dst_addr = dst_base_q + AW'(dst_off) + AW'(b_q);
  assign last_k   = {vs_q, hs_q};
  assign acc_sh   = {vs_q, hs_q & ~vs_q};
  assign rd_last  = {1'b0, b_q} == sbpp - 3'd1;
  assign wr_last  = {1'b0, b_q} == dbpp - 3'd1;
  assign acc_clr  = (st_q == S_IDLE) | ((st_q == S_WR) & wr_last);
  assign px_in    = px_decode(in_fmt_q, buf_q);

  blit_accum u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(acc_clr), .add_i(st_q == S_ACC),
    .px_i(px_in), .sh_i(acc_sh), .avg_o(px_avg)
  );

  assign enc         = px_encode(out_fmt_q, px_avg);
  assign busy_o      = st_q != S_IDLE;
  assign mem_rd_o    = st_q == S_RD;
  assign mem_wr_o    = st_q == S_WR;
  assign mem_addr_o  = mem_wr_o ? dst_addr : src_addr;
  assign mem_wdata_o = enc[{b_q, 3'b000} +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      src_base_q <= '0; dst_base_q <= '0;
      in_w_q <= '0; ow_q <= '0; oh_q <= '0; x_q <= '0; y_q <= '0;
      in_fmt_q <= '0; out_fmt_q <= '0;
      src_tiled_q <= 1'b0; dst_tiled_q <= 1'b0; flip_q <= 1'b0; hs_q <= 1'b0; vs_q <= 1'b0;
      k_q <= '0; b_q <= '0; buf_q <= '0;
      done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (reject) err_o <= 1'b1;
          else begin
            src_base_q  <= src_base_i;
            dst_base_q  <= dst_base_i;
            in_w_q      <= in_w_i;
            ow_q        <= ow_n;
            oh_q        <= oh_n;
            in_fmt_q    <= in_fmt_i;
            out_fmt_q   <= out_fmt_i;
            src_tiled_q <= ~lin_in_i;
            dst_tiled_q <= lin_in_i ^ keep_layout_i;
            flip_q      <= flip_i;
            hs_q        <= hs_n;
            vs_q        <= vs_n;
            x_q <= '0; y_q <= '0; k_q <= '0; b_q <= '0;
            if (ow_n == '0 || oh_n == '0) done_o <= 1'b1;
            else st_q <= S_RD;
          end
        end
        S_RD: st_q <= S_CAP;
        S_CAP: begin
          buf_q[b_q] <= mem_rdata_i;
          if (rd_last) begin b_q <= '0; st_q <= S_ACC; end
          else begin b_q <= b_q + 2'd1; st_q <= S_RD; end
        end
        S_ACC: begin
          if (k_q == last_k) begin k_q <= '0; st_q <= S_WR; end
          else begin k_q <= k_q + 2'd1; st_q <= S_RD; end
        end
        S_WR: begin
          if (wr_last) begin
            b_q  <= '0;
            st_q <= S_RD;
            if (x_q == ow_q - CW'(1)) begin
              x_q <= '0;
              if (y_q == oh_q - CW'(1)) begin
                st_q   <= S_IDLE;
                done_o <= 1'b1;
              end else y_q <= y_q + CW'(1);
            end else x_q <= x_q + CW'(1);
          end else b_q <= b_q + 2'd1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blit_xfer_chk.sv
module blit_xfer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic mem_rd_o,
  input logic mem_wr_o
);
  assert_rw_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_rd_o && !mem_wr_o));
  assert_rd_spaced_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_err_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(start_i) && !busy_o && !done_o));
endmodule

bind blit_xfer blit_xfer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o)
);

// File: tb/blit_xfer_bench.sv
`timescale 1ns/1ps
module blit_xfer_bench;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam int DST = 2048;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] src_base, dst_base, mem_addr;
  logic [CW-1:0] in_w, in_h, out_w, out_h;
  logic [2:0] in_fmt, out_fmt;
  logic lin_in, keep_lay, flip;
  logic [1:0] scale;
  logic busy, done, err, mem_rd, mem_wr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [0:4095];
  logic [7:0] exp_m [0:1023];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  blit_xfer #(.AW(AW), .CW(CW)) u_blit_xfer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_base_i(src_base), .dst_base_i(dst_base),
    .in_w_i(in_w), .in_h_i(in_h), .out_w_i(out_w), .out_h_i(out_h),
    .in_fmt_i(in_fmt), .out_fmt_i(out_fmt), .lin_in_i(lin_in), .keep_layout_i(keep_lay),
    .flip_i(flip), .scale_i(scale), .busy_o(busy), .done_o(done), .err_o(err),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= wdata;
    if (mem_rd) rdata <= mem[mem_addr];
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(190000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // model of the requirements
  function automatic int bpp_f(int f);
    return (f == 0) ? 4 : ((f == 1) ? 3 : 2);
  endfunction

  function automatic int widen(int v, int n);
    if (n == 8) return v;
    if (n == 1) return v ? 255 : 0;
    return (v << (8 - n)) | (v >> (2 * n - 8));
  endfunction

  function automatic int dec_f(int f, int raw);
    int r, g, b, a;
    case (f)
      0: begin r = (raw >> 24) & 255; g = (raw >> 16) & 255; b = (raw >> 8) & 255; a = raw & 255; end
      1: begin r = (raw >> 16) & 255; g = (raw >> 8) & 255; b = raw & 255; a = 255; end
      2: begin r = widen((raw >> 11) & 31, 5); g = widen((raw >> 5) & 63, 6);
               b = widen(raw & 31, 5); a = 255; end
      3: begin r = widen((raw >> 11) & 31, 5); g = widen((raw >> 6) & 31, 5);
               b = widen((raw >> 1) & 31, 5); a = widen(raw & 1, 1); end
      default: begin r = widen((raw >> 12) & 15, 4); g = widen((raw >> 8) & 15, 4);
                     b = widen((raw >> 4) & 15, 4); a = widen(raw & 15, 4); end
    endcase
    return (r << 24) | (g << 16) | (b << 8) | a;
  endfunction

  function automatic int enc_f(int f, int r, int g, int b, int a);
    case (f)
      0: return (r << 24) | (g << 16) | (b << 8) | a;
      1: return (r << 16) | (g << 8) | b;
      2: return ((r / 8) << 11) | ((g / 4) << 5) | (b / 8);
      3: return ((r / 8) << 11) | ((g / 8) << 6) | ((b / 8) << 1) | (a >= 128 ? 1 : 0);
      default: return ((r / 16) << 12) | ((g / 16) << 8) | ((b / 16) << 4) | (a / 16);
    endcase
  endfunction

  function automatic int off_f(int x, int y, int w, bit tiled, int bpp);
    int m;
    if (!tiled) return (y * w + x) * bpp;
    m = (x & 1) | ((y & 1) << 1) | ((x & 2) << 1) | ((y & 2) << 2) | ((x & 4) << 2) | ((y & 4) << 3);
    return ((y / 8) * 8 * w + (x / 8) * 64 + m) * bpp;
  endfunction

  task automatic model(int fi, int fo, int lin, int nosw, int flp, int sc, int iw, int ow_c, int oh_c);
    int hs, vs, ow, oh, sb, db, n;
    bit st, dt;
    hs = (sc != 0); vs = (sc == 2);
    ow = ow_c >> hs; oh = oh_c >> vs; n = 1 << (hs + vs);
    sb = bpp_f(fi); db = bpp_f(fo);
    st = !lin; dt = lin ? !nosw : nosw;
    for (int i = 0; i < 1024; i++) exp_m[i] = 8'ha5;
    for (int y = 0; y < oh; y++)
      for (int x = 0; x < ow; x++) begin
        int so, dof, oy, sr, sg, sbl, sa, w;
        oy = flp ? (oh - 1 - y) : y;
        so = off_f(x << hs, y << vs, iw, st, sb);
        dof = off_f(x, oy, ow, dt, db);
        sr = 0; sg = 0; sbl = 0; sa = 0;
        for (int k = 0; k < n; k++) begin
          int raw, p;
          raw = 0;
          for (int j = 0; j < sb; j++) raw |= int'(mem[so + k * sb + j]) << (8 * j);
          p = dec_f(fi, raw);
          sr += (p >> 24) & 255; sg += (p >> 16) & 255; sbl += (p >> 8) & 255; sa += p & 255;
        end
        w = enc_f(fo, sr / n, sg / n, sbl / n, sa / n);
        for (int j = 0; j < db; j++) exp_m[dof + j] = 8'((w >> (8 * j)) & 255);
      end
  endtask

  task automatic cmp_dst(string req);
    int bad, first, av, ev;
    bad = 0; first = -1; av = 0; ev = 0;
    for (int i = 0; i < 1024; i++)
      if (mem[DST + i] !== exp_m[i]) begin
        if (first < 0) begin first = i; av = mem[DST + i]; ev = exp_m[i]; end
        bad++;
      end
    chk(bad == 0, req, $sformatf("dst byte %0d (of %0d bad)", first, bad), av, ev);
  endtask

  task automatic run(int fi, int fo, int lin, int nosw, int flp, int sc,
                     int iw, int ih, int ow_c, int oh_c, string req, bit disturb);
    bit rej, empty;
    for (int i = 0; i < 1024; i++) mem[DST + i] = 8'ha5;
    rej = (sc == 3) || (lin != 0 && sc != 0) || iw == 0 || ih == 0 || ow_c == 0 || oh_c == 0 ||
          fi > 4 || fo > 4;
    empty = ((ow_c >> (sc != 0)) == 0) || ((oh_c >> (sc == 2)) == 0);
    if (rej) for (int i = 0; i < 1024; i++) exp_m[i] = 8'ha5;
    else model(fi, fo, lin, nosw, flp, sc, iw, ow_c, oh_c);
    @(negedge clk);
    src_base = '0; dst_base = AW'(DST);
    in_w = CW'(iw); in_h = CW'(ih); out_w = CW'(ow_c); out_h = CW'(oh_c);
    in_fmt = 3'(fi); out_fmt = 3'(fo); lin_in = lin[0]; keep_lay = nosw[0];
    flip = flp[0]; scale = 2'(sc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (rej) begin
      chk(err === 1'b1 && busy === 1'b0, "R8", "err/busy after refused start", {err, busy}, 2'b10);
      repeat (4) @(negedge clk);
      chk(busy === 1'b0, "R8", "busy stays low", busy, 0);
      cmp_dst("R8");
      return;
    end
    if (empty) chk(done === 1'b1 && busy === 1'b0, "R5", "empty walk done", {done, busy}, 2'b10);
    else chk(busy === 1'b1 && err === 1'b0, "R9", "busy after start", {busy, err}, 2'b10);
    if (disturb) begin
      dst_base = '0; in_fmt = 3'd1; out_fmt = 3'd0; flip = ~flip; scale = 2'd0; out_w = 8'd3;
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9", "done single pulse", {done, busy}, 0);
    cmp_dst(req);
  endtask

  initial begin
    int seed;
    seed = 32'h1234567;
    for (int i = 0; i < 4096; i++) begin
      seed = seed * 1103515245 + 12345;
      mem[i] = 8'((seed >> 16) & 255);
    end
    src_base = '0; dst_base = '0; in_w = '0; in_h = '0; out_w = '0; out_h = '0;
    in_fmt = '0; out_fmt = '0; lin_in = 1'b0; keep_lay = 1'b0; flip = 1'b0; scale = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, err, mem_rd, mem_wr} === 5'b0, "R10", "reset outputs",
        {busy, done, err, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, mem_rd, mem_wr} === 5'b0, "R9", "idle after reset",
        {busy, done, err, mem_rd, mem_wr}, 0);
    // R1 R2: every format pair, layout mode rotated
    for (int fi = 0; fi < 5; fi++)
      for (int fo = 0; fo < 5; fo++) begin
        int m;
        m = (fi + fo) % 4;
        run(fi, fo, m / 2, m % 2, 0, 0, 8, 8, 8, 8, "R1/R2 format pair", 1'b0);
      end
    // R3 R4 R7: layout modes with and without mirror
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        run(0, 3, m / 2, m % 2, f, 0, 16, 16, 16, 8, "R3/R4/R7 layout+flip", 1'b0);
    run(0, 0, 0, 0, 0, 0, 24, 8, 24, 8, "R4 tile columns", 1'b0);
    // R5 R6 R7: downscale on tiled input
    for (int sc = 1; sc < 3; sc++)
      for (int ns = 0; ns < 2; ns++)
        for (int f = 0; f < 2; f++)
          run(4, 0, 0, ns, f, sc, 16, 16, 16, 16, "R5/R6 downscale", 1'b0);
    run(0, 0, 0, 0, 0, 1, 8, 8, 1, 8, "R5 empty walk", 1'b0);
    // R8 refusals
    run(0, 0, 0, 0, 0, 3, 8, 8, 8, 8, "R8", 1'b0);
    run(0, 0, 1, 0, 0, 1, 8, 8, 8, 8, "R8", 1'b0);
    run(0, 0, 0, 0, 0, 0, 0, 8, 8, 8, "R8", 1'b0);
    run(0, 0, 0, 0, 0, 0, 8, 8, 8, 0, "R8", 1'b0);
    run(5, 0, 0, 0, 0, 0, 8, 8, 8, 8, "R8", 1'b0);
    // R11: restart and new config while busy
    run(2, 0, 0, 0, 1, 2, 16, 16, 16, 16, "R11 ignore while busy", 1'b1);
    summary();
  end
endmodule